// File: doc/BRIEF.md
# Overtemperature Ideal-Diode Gate Controller

This block takes over the gate of a power switch while the switch sits in thermal shutdown. In that condition the controller acts as a plain ideal diode. It closes the gate when the drain is pulled negative, which shows that reverse current is flowing. It opens the gate again as soon as forward current is detected.

Each falling edge of the external switching command starts a fixed blanking interval, during which the gate stays open and the drain is not watched. This gives the opposite switch of the leg time to commutate. A fixed time is used instead of waiting for a positive drain voltage, so the controller can never get stuck. There is no lockout, so conduction and blocking may alternate without limit.

All four inputs are asynchronous and pass through two-flop synchronizers. The gate enable and the reported state number are registered. The blank length `BLANK_CYC` is a parameter in clock cycles and must be at least 1.

Top module: `ot_diode_ctrl`

## Requirements
- R1: A change on any input first affects `state_o` and `gate_o` on the third rising clock edge after the change (two synchronizer stages, then the state register).
- R2: While reset is active, and whenever the synchronized shutdown flag is low, `state_o` is 0 and `gate_o` is 0.
- R3: When the shutdown flag becomes high with no command falling edge, the controller leaves state 0 and enters state 2 (blocking, watching the drain).
- R4: While in shutdown, a falling edge of `cmd_i` moves the controller to state 1 with the gate off, from any state. This edge takes priority over the drain-voltage and forward-current flags.
- R5: State 1 lasts exactly `BLANK_CYC` cycles, and both drain flags are ignored during it. The controller then moves to state 2.
- R6: A new command falling edge that arrives while in state 1 restarts the full blank period of `BLANK_CYC` cycles.
- R7: In state 2, the negative-drain flag moves the controller to state 3.
- R8: In state 3, the forward-current flag moves the controller back to state 2.
- R9: `gate_o` is 1 exactly when `state_o` is 3.
- R10: A rising edge of `cmd_i` has no effect on the state or the gate while in shutdown.
- R11: With no command activity, the controller alternates between states 2 and 3 any number of times, with no count limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shdn_i | input | 1 | High while the switch is in thermal shutdown (asynchronous) |
| cmd_i | input | 1 | Switching command from the controller (asynchronous) |
| neg_vds_i | input | 1 | Drain voltage is negative, meaning reverse current flows (asynchronous) |
| fwd_cur_i | input | 1 | Forward drain current detected (asynchronous) |
| gate_o | output | 1 | Registered gate enable |
| state_o | output | 2 | Registered state: 0 idle, 1 blanking, 2 blocking, 3 conducting |

## Verification
The assertions are written on the synchronized versions of the inputs, so they assume that each input holds its level long enough to pass the two-flop chain. A pulse shorter than one clock may be lost, and such a pulse is not part of the contract. The stimulus changes inputs only at falling clock edges and keeps each level for at least one full cycle. Command toggles are rare, so the blank, the 2-to-3 alternation and restarts in the middle of a blank all occur. The shutdown flag is dropped only now and then, to exercise the idle path.

// File: rtl/ot_diode_ctrl.sv
module ot_diode_ctrl #(
  parameter int BLANK_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_i,
  input  logic       cmd_i,
  input  logic       neg_vds_i,
  input  logic       fwd_cur_i,
  output logic       gate_o,
  output logic [1:0] state_o
);
  localparam int CW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);
  localparam logic [CW-1:0] RELOAD = CW'(BLANK_CYC - 1);
  localparam logic [1:0] S_IDLE  = 2'd0;
  localparam logic [1:0] S_BLANK = 2'd1;
  localparam logic [1:0] S_WATCH = 2'd2;
  localparam logic [1:0] S_COND  = 2'd3;

  logic [1:0] shdn_q, neg_q, fwd_q;
  logic [2:0] cmd_q;
  logic       shdn_s, neg_s, fwd_s, fall_s;
  logic [1:0] st, st_n;
  logic [CW-1:0] cnt, cnt_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shdn_q <= '0;
      neg_q  <= '0;
      fwd_q  <= '0;
      cmd_q  <= '0;
    end else begin
      shdn_q <= {shdn_q[0], shdn_i};
      neg_q  <= {neg_q[0], neg_vds_i};
      fwd_q  <= {fwd_q[0], fwd_cur_i};
      cmd_q  <= {cmd_q[1:0], cmd_i};
    end

  assign shdn_s = shdn_q[1];
  assign neg_s  = neg_q[1];
  assign fwd_s  = fwd_q[1];
  assign fall_s = cmd_q[2] & ~cmd_q[1];

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (!shdn_s) begin
      st_n  = S_IDLE;
      cnt_n = '0;
    end else if (fall_s) begin
      st_n  = S_BLANK;
      cnt_n = RELOAD;
    end else begin
      case (st)
        S_IDLE:  st_n = S_WATCH;
        S_BLANK: if (cnt == '0) st_n = S_WATCH;
                 else cnt_n = cnt - CW'(1);
        S_WATCH: if (neg_s) st_n = S_COND;
        default: if (fwd_s) st_n = S_WATCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      gate_o <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      gate_o <= (st_n == S_COND);
    end

  assign state_o = st;
endmodule

module ot_diode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       shdn_s,
  input logic       fall_s,
  input logic       neg_s,
  input logic       fwd_s,
  input logic       gate_o,
  input logic [1:0] state_o
);
  p_gate_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o == (state_o == 2'd3));
  p_idle_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_s |=> (state_o == 2'd0 && !gate_o));
  p_enter_watch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_s && !fall_s && state_o == 2'd0) |=> state_o == 2'd2);
  p_fall_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_s && fall_s) |=> (state_o == 2'd1 && !gate_o));
  p_blank_no_conduct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'd1 |=> state_o != 2'd3);
  p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_s && !fall_s && state_o == 2'd2 && neg_s) |=> state_o == 2'd3);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_s && !fall_s && state_o == 2'd3 && fwd_s) |=> state_o == 2'd2);
endmodule

bind ot_diode_ctrl ot_diode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .shdn_s(shdn_s), .fall_s(fall_s),
  .neg_s(neg_s), .fwd_s(fwd_s), .gate_o(gate_o), .state_o(state_o)
);

// File: tb/sim_ot_diode_ctrl.sv
`timescale 1ns/1ps
module sim_ot_diode_ctrl;
  localparam int BLANK = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic shdn = 1'b0, cmd = 1'b0, neg = 1'b0, fwd = 1'b0;
  logic gate;
  logic [1:0] st;
  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  ot_diode_ctrl #(.BLANK_CYC(BLANK)) u0 (
    .clk(clk), .rst_n(rst_n), .shdn_i(shdn), .cmd_i(cmd),
    .neg_vds_i(neg), .fwd_cur_i(fwd), .gate_o(gate), .state_o(st));

  logic [1:0] ps, pn, pf;
  logic [2:0] pc;
  logic [1:0] m_st;
  int m_cnt;
  string m_tag;

  function automatic logic [1:0] ref_next(logic [1:0] s, int c, logic sd,
                                          logic fl, logic ng, logic fw);
    if (!sd) return 2'd0;
    if (fl) return 2'd1;
    case (s)
      2'd0: return 2'd2;
      2'd1: return (c == 0) ? 2'd2 : 2'd1;
      2'd2: return ng ? 2'd3 : 2'd2;
      default: return fw ? 2'd2 : 2'd3;
    endcase
  endfunction

  function automatic string ref_tag(logic [1:0] s, logic sd, logic fl, logic rise);
    if (!sd) return "R2";
    if (fl) return (s == 2'd1) ? "R6" : "R4";
    case (s)
      2'd0: return "R3";
      2'd1: return "R5";
      2'd2: return rise ? "R10" : "R7";
      default: return rise ? "R10" : "R11";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ps <= '0; pn <= '0; pf <= '0; pc <= '0;
      m_st <= 2'd0; m_cnt <= 0; m_tag <= "R2";
    end else begin
      logic fl, ri;
      fl = pc[2] & ~pc[1];
      ri = ~pc[2] & pc[1];
      ps <= {ps[0], shdn}; pn <= {pn[0], neg};
      pf <= {pf[0], fwd};  pc <= {pc[1:0], cmd};
      m_st  <= ref_next(m_st, m_cnt, ps[1], fl, pn[1], pf[1]);
      m_tag <= ref_tag(m_st, ps[1], fl, ri);
      if (!ps[1]) m_cnt <= 0;
      else if (fl) m_cnt <= BLANK - 1;
      else if (m_st == 2'd1 && m_cnt != 0) m_cnt <= m_cnt - 1;
    end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic s, logic c, logic n, logic f, int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      chk(st == m_st, m_tag, st, m_st);
      chk(gate == (m_st == 2'd3), "R9", gate, m_st == 2'd3);
      shdn = s; cmd = c; neg = n; fwd = f;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(st == 2'd0 && gate == 1'b0, "R2", st, 0);
    rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b1, 1'b0, 6);
    // R1: shutdown raised at this edge, state moves on the third rising edge
    @(negedge clk); shdn = 1'b1;
    @(negedge clk); chk(st == 2'd0, "R1", st, 0);
    @(negedge clk); chk(st == 2'd0, "R1", st, 0);
    @(negedge clk); chk(st == 2'd2, "R1", st, 2);
    step(1'b1, 1'b1, 1'b0, 1'b0, 4);
    for (int k = 0; k < 5; k++) begin   // R11 repeated alternation
      step(1'b1, 1'b1, 1'b1, 1'b0, 4);
      step(1'b1, 1'b1, 1'b0, 1'b1, 4);
    end
    step(1'b1, 1'b1, 1'b1, 1'b0, 4);
    step(1'b1, 1'b0, 1'b1, 1'b0, 20);   // R4 from state 3, R5 flags ignored
    step(1'b1, 1'b1, 1'b1, 1'b0, 3);    // R10 rise inside blank
    step(1'b1, 1'b0, 1'b1, 1'b0, 60);   // R6 restart, then R5 expiry, R7
    step(1'b1, 1'b1, 1'b0, 1'b1, 5);
    step(1'b0, 1'b1, 1'b1, 1'b0, 6);    // R2 idle while shutdown low
    for (int i = 0; i < 20000; i++) begin : rnd
      logic s, c, n, f;
      s = ($urandom % 300 == 0) ? ~shdn : shdn;
      c = ($urandom % 70 == 0) ? ~cmd : cmd;
      n = ($urandom % 6 == 0);
      f = ($urandom % 6 == 0);
      if (!s && $urandom % 4 == 0) s = 1'b1;
      step(s, c, n, f, 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule